// File: doc/BRIEF.md
# SPI NAND Page Cache Reader

This block reads a whole page out of the cache of a serial NAND device. It frames one transaction by holding chip select low. Inside that frame it shifts out a read opcode, then a 16-bit column address, then a programmable number of idle dummy clocks. After that it receives the page as a run of sectors. Each sector holds a fixed number of main bytes plus a programmable number of spare bytes. Every byte received is presented on a byte-wide output with a one-cycle valid strobe.

A counter output reports how many complete sectors have arrived. This lets the surrounding logic see when the page is in. On the final byte a done event sets a pending interrupt flag, but only if the interrupt enable is high. A read strobe clears the flag.

The data phase can use one, two or four lanes. The address phase can follow the data width or stay on one lane. The opcode always goes out on one lane. Each serial bit slot takes two system clocks: SCK is low in the first and high in the second. Input lanes are sampled on the SCK rising edge.

Top module: `spinand_cache_reader`

## Requirements
- R1: The opcode is sent first on io_out[0] only (io_oe = 4'b0001), one bit per SCK period, most significant bit first.
- R2: The 16-bit column address follows the opcode, most significant bits first. If lane_mode[2] is 0 it is sent on io_out[0] (io_oe = 4'b0001). If lane_mode[2] is 1 it uses the data width, with the higher lane carrying the more significant bit: io[1:0] with io_oe = 4'b0011 for dual, io[3:0] with io_oe = 4'b1111 for quad.
- R3: After the address come exactly dummy_clks SCK periods during which io_oe is 0. A count of 0 skips the phase.
- R4: lane_mode[1:0] selects the data width: 0 is one lane on io_in[1], 1 is two lanes io_in[1:0], 2 is four lanes io_in[3:0]. Bits arrive most significant first, and the highest lane carries the most significant bit of each group. Each assembled byte appears on rx_data with rx_valid high for one cycle. io_oe is 0 during the data phase.
- R5: A transfer delivers exactly sectors × (SECTOR_BYTES + spare_bytes) bytes, then raises cs_n.
- R6: sect_cnt clears when a transfer starts. It rises by one in the cycle that presents the last byte of each sector, and it ends equal to sectors.
- R7: No transfer starts while rd_en is 0. After a transfer completes, the block stays idle with cs_n high while rd_en remains 1. A new transfer needs rd_en to be cleared and then set again.
- R8: irq_pend becomes 1 in the cycle that presents the final byte, and only if irq_en is 1. With irq_en at 0 it stays 0.
- R9: A cycle with irq_rd high clears irq_pend on the following cycle, unless a done event occurs in that same cycle.
- R10: Dropping rd_en during a transfer ends it. cs_n is high and SCK low one clock later, no done event occurs, and the next transfer starts cleanly.
- R11: A transfer with sectors = 0 ends right after the dummy phase. It delivers no byte, leaves sect_cnt at 0 and raises the done event.
- R12: After reset cs_n is 1, sck is 0, io_oe is 0, rx_valid is 0, sect_cnt is 0 and irq_pend is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Cache-read enable; a transfer starts when it is seen high while idle |
| opcode | input | 8 | Read-from-cache opcode |
| dummy_clks | input | DUMMY_W | Number of dummy SCK periods |
| col_addr | input | 16 | Column address within the page |
| lane_mode | input | 3 | [1:0] data width code, [2] address uses the data width |
| sectors | input | SECT_W | Sectors in the page |
| spare_bytes | input | SPARE_W | Spare bytes following each sector's main bytes |
| irq_en | input | 1 | Done interrupt enable |
| irq_rd | input | 1 | Status read strobe; clears irq_pend |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | rx_data holds a new byte this cycle |
| sect_cnt | output | SECT_W | Completed sectors in the current transfer |
| irq_pend | output | 1 | Done interrupt pending |

## Verification
The assertions assume that the configuration inputs stay constant while a transfer is running. They also assume that lane_mode[1:0] is never 3, and that the device drives io_in only after the dummy clocks. The stimulus changes the configuration only while cs_n is high, before raising rd_en. It uses only codes 0, 1 and 2 for the data width. The bench's device model starts driving data on the first SCK fall after the last dummy clock. It updates its lanes only on falling SCK edges, which keeps them stable around every rising-edge sample.

// File: rtl/spinand_cache_reader.sv
module spinand_cache_reader #(
  parameter int SECTOR_BYTES = 512,
  parameter int SECT_W       = 5,
  parameter int SPARE_W      = 8,
  parameter int DUMMY_W      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [7:0]         opcode,
  input  logic [DUMMY_W-1:0] dummy_clks,
  input  logic [15:0]        col_addr,
  input  logic [2:0]         lane_mode,
  input  logic [SECT_W-1:0]  sectors,
  input  logic [SPARE_W-1:0] spare_bytes,
  input  logic               irq_en,
  input  logic               irq_rd,
  output logic               sck,
  output logic               cs_n,
  output logic [3:0]         io_out,
  output logic [3:0]         io_oe,
  input  logic [3:0]         io_in,
  output logic [7:0]         rx_data,
  output logic               rx_valid,
  output logic [SECT_W-1:0]  sect_cnt,
  output logic               irq_pend
);

  localparam int BYTE_W = $clog2(SECTOR_BYTES + 2**SPARE_W);
  localparam int CNT_W  = (DUMMY_W > 5) ? DUMMY_W : 5;

  typedef enum logic [2:0] {ST_IDLE, ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA, ST_DONE} st_t;

  st_t                st;
  logic               ph;
  logic [CNT_W-1:0]   cnt;
  logic [15:0]        sh;
  logic [7:0]         rsh;
  logic [2:0]         bcnt;
  logic [BYTE_W-1:0]  bsec;
  logic [SECT_W-1:0]  sect_q, sect_n;
  logic [SPARE_W-1:0] spare_q;
  logic [DUMMY_W-1:0] dum_q;
  logic [1:0]         dlog, alog;
  logic               last_q, irq_q, rxv_q;
  logic [7:0]         rxd_q;

  logic [1:0]         dlog_in;
  logic [4:0]         a_m1;
  logic [2:0]         b_m1;
  logic [BYTE_W-1:0]  sec_last;
  logic [7:0]         rx_next;
  logic               active, byte_end, sect_end, addr_last, dum_last;
  logic               zero_fin, data_fin, fin;
  st_t                after_setup;

  assign dlog_in  = (lane_mode[1:0] == 2'd1) ? 2'd1 : (lane_mode[1:0] == 2'd2) ? 2'd2 : 2'd0;
  assign a_m1     = (5'd16 >> alog) - 5'd1;
  assign b_m1     = 3'((4'd8 >> dlog) - 4'd1);
  assign sec_last = BYTE_W'(SECTOR_BYTES) + BYTE_W'(spare_q) - BYTE_W'(1);
  assign active   = (st == ST_CMD) || (st == ST_ADDR) || (st == ST_DUMMY) || (st == ST_DATA);
  assign byte_end = (bcnt == b_m1);
  assign sect_end = (bsec == sec_last);
  assign addr_last = (st == ST_ADDR) && (cnt == CNT_W'(a_m1));
  assign dum_last  = (st == ST_DUMMY) && (cnt == CNT_W'(dum_q - DUMMY_W'(1)));
  assign after_setup = (sect_n == '0) ? ST_DONE : ST_DATA;

  assign zero_fin = ph && (sect_n == '0) && ((addr_last && dum_q == '0) || dum_last);
  assign data_fin = (st == ST_DATA) && !ph && byte_end && sect_end &&
                    ((sect_q + SECT_W'(1)) == sect_n);
  assign fin      = rd_en && (zero_fin || data_fin);

  always_comb begin
    case (dlog)
      2'd0:    rx_next = {rsh[6:0], io_in[1]};
      2'd1:    rx_next = {rsh[5:0], io_in[1:0]};
      default: rx_next = {rsh[3:0], io_in[3:0]};
    endcase
  end

  always_comb begin
    io_out = 4'b0000;
    io_oe  = 4'b0000;
    if (st == ST_CMD) begin
      io_out = {3'b000, sh[15]};
      io_oe  = 4'b0001;
    end else if (st == ST_ADDR) begin
      case (alog)
        2'd0:    begin io_out = {3'b000, sh[15]};    io_oe = 4'b0001; end
        2'd1:    begin io_out = {2'b00, sh[15:14]};  io_oe = 4'b0011; end
        default: begin io_out = sh[15:12];           io_oe = 4'b1111; end
      endcase
    end
  end

  assign sck      = active && ph;
  assign cs_n     = !active;
  assign rx_data  = rxd_q;
  assign rx_valid = rxv_q;
  assign sect_cnt = sect_q;
  assign irq_pend = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; ph <= 1'b0; cnt <= '0; sh <= '0; rsh <= '0;
      bcnt <= '0; bsec <= '0; sect_q <= '0; sect_n <= '0; spare_q <= '0;
      dum_q <= '0; dlog <= 2'd0; alog <= 2'd0; last_q <= 1'b0;
      rxv_q <= 1'b0; rxd_q <= '0;
    end else begin
      rxv_q <= 1'b0;
      if (st == ST_IDLE) begin
        if (rd_en) begin
          st <= ST_CMD; ph <= 1'b0; cnt <= '0;
          sh <= {opcode, 8'h00};
          dlog <= dlog_in;
          alog <= lane_mode[2] ? dlog_in : 2'd0;
          sect_n <= sectors; spare_q <= spare_bytes; dum_q <= dummy_clks;
          sect_q <= '0; bsec <= '0; bcnt <= '0; last_q <= 1'b0;
        end
      end else if (st == ST_DONE) begin
        if (!rd_en) st <= ST_IDLE;
      end else if (!rd_en) begin
        st <= ST_IDLE;
        ph <= 1'b0;
      end else begin
        ph <= ~ph;
        if (ph) begin
          case (st)
            ST_CMD: begin
              sh <= sh << 1;
              if (cnt == CNT_W'(7)) begin
                st <= ST_ADDR; cnt <= '0; sh <= col_addr;
              end else cnt <= cnt + CNT_W'(1);
            end
            ST_ADDR: begin
              sh <= sh << (5'd1 << alog);
              if (addr_last) begin
                cnt <= '0;
                st  <= (dum_q != '0) ? ST_DUMMY : after_setup;
              end else cnt <= cnt + CNT_W'(1);
            end
            ST_DUMMY: begin
              if (dum_last) begin
                cnt <= '0; st <= after_setup;
              end else cnt <= cnt + CNT_W'(1);
            end
            ST_DATA: if (last_q) st <= ST_DONE;
            default: st <= st;
          endcase
        end else if (st == ST_DATA) begin
          rsh <= rx_next;
          if (byte_end) begin
            bcnt  <= '0;
            rxd_q <= rx_next;
            rxv_q <= 1'b1;
            if (sect_end) begin
              bsec   <= '0;
              sect_q <= sect_q + SECT_W'(1);
              if ((sect_q + SECT_W'(1)) == sect_n) last_q <= 1'b1;
            end else bsec <= bsec + BYTE_W'(1);
          end else bcnt <= bcnt + 3'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                irq_q <= 1'b0;
    else if (fin && irq_en)    irq_q <= 1'b1;
    else if (irq_rd)           irq_q <= 1'b0;
  end

  AST_CMD_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CMD) |-> (io_oe == 4'b0001)); // R1
  AST_DATA_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (io_oe == 4'b0000)); // R4
  AST_SECT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> (sect_cnt <= sect_n)); // R6
  AST_SECT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!cs_n) && !cs_n && !$stable(sect_cnt)) |-> (sect_cnt == SECT_W'($past(sect_cnt) + 1'b1))); // R6
  AST_SCK_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !cs_n); // R7
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pend) |-> $past(irq_en)); // R8
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rd && irq_pend && !fin) |=> !irq_pend); // R9
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (cs_n && !sck)); // R10

endmodule

// File: tb/test_spinand_cache_reader.sv
module test_spinand_cache_reader;
  logic       clk = 1'b0, rst_n = 1'b0, rd_en = 1'b0;
  logic [7:0] opcode = '0, dummy_clks = '0, spare_bytes = '0;
  logic [15:0] col_addr = '0;
  logic [2:0] lane_mode = '0;
  logic [4:0] sectors = '0;
  logic       irq_en = 1'b0, irq_rd = 1'b0;
  logic [3:0] io_in = '0;
  logic       sck, cs_n, rx_valid, irq_pend;
  logic [3:0] io_out, io_oe;
  logic [7:0] rx_data;
  logic [4:0] sect_cnt;

  spinand_cache_reader i_spinand_cache_reader (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .opcode(opcode), .dummy_clks(dummy_clks),
    .col_addr(col_addr), .lane_mode(lane_mode), .sectors(sectors), .spare_bytes(spare_bytes),
    .irq_en(irq_en), .irq_rd(irq_rd), .sck(sck), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe),
    .io_in(io_in), .rx_data(rx_data), .rx_valid(rx_valid), .sect_cnt(sect_cnt), .irq_pend(irq_pend));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  int cur_w = 1, cur_aw = 1, n_as = 16, n_dum = 0;
  int rises = 0, dslot = 0, nbytes = 0, tot = 0, sec_len = 512;
  logic [7:0] cap_cmd;
  logic [15:0] cap_addr;
  bit bad_cmd, bad_addr, bad_dum, bad_data;
  bit chk_irq = 1'b1, exp_irq = 1'b0, rd_seen = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 29) ^ (k >> 8) ^ 8'h5B);
  endfunction

  function automatic logic [3:0] amask(input int w);
    return (w == 1) ? 4'b0001 : (w == 2) ? 4'b0011 : 4'b1111;
  endfunction

  // behavioural serial NAND device
  always @(negedge cs_n) begin
    rises = 0; dslot = 0; cap_cmd = '0; cap_addr = '0;
  end

  always @(posedge sck) begin
    if (rises < 8) begin
      cap_cmd = {cap_cmd[6:0], io_out[0]};
      if (io_oe !== 4'b0001) bad_cmd = 1'b1;
    end else if (rises < 8 + n_as) begin
      cap_addr = (cap_addr << cur_aw) | 16'(io_out & amask(cur_aw));
      if (io_oe !== amask(cur_aw)) bad_addr = 1'b1;
    end else if (rises < 8 + n_as + n_dum) begin
      if (io_oe !== 4'b0000) bad_dum = 1'b1;
    end else if (io_oe !== 4'b0000) bad_data = 1'b1;
    rises++;
  end

  always @(negedge sck) begin
    if (rises >= 8 + n_as + n_dum) begin
      int spb, k, j;
      logic [7:0] b, v;
      spb = 8 / cur_w;
      k = dslot / spb;
      j = dslot % spb;
      b = pat(k);
      v = b >> (8 - (j + 1) * cur_w);
      if (cur_w == 1) io_in <= {2'b00, v[0], 1'b0};
      else if (cur_w == 2) io_in <= {2'b00, v[1:0]};
      else io_in <= v[3:0];
      dslot++;
    end
  end

  always @(posedge clk) rd_seen <= irq_rd;

  // per-clock reference comparison
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        chk(rx_data == pat(nbytes), "R4 byte", rx_data, pat(nbytes));
        nbytes++;
      end
      if (rd_seen) exp_irq = 1'b0;
      if (rx_valid && nbytes == tot && irq_en) exp_irq = 1'b1;
      if (!cs_n) chk(sect_cnt == 5'(nbytes / sec_len), "R6 live", sect_cnt, nbytes / sec_len);
      if (chk_irq) chk(irq_pend == exp_irq, "R8 live", irq_pend, exp_irq);
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic setup(input logic [7:0] op, input logic [7:0] dum, input logic [15:0] col,
                       input logic [2:0] mode, input logic [4:0] ns, input logic [7:0] sp, input bit ien);
    @(negedge clk);
    opcode = op; dummy_clks = dum; col_addr = col; lane_mode = mode;
    sectors = ns; spare_bytes = sp; irq_en = ien;
    cur_w  = (mode[1:0] == 2'd1) ? 2 : (mode[1:0] == 2'd2) ? 4 : 1;
    cur_aw = mode[2] ? cur_w : 1;
    n_as = 16 / cur_aw; n_dum = dum;
    sec_len = 512 + sp; tot = ns * sec_len; nbytes = 0;
    bad_cmd = 0; bad_addr = 0; bad_dum = 0; bad_data = 0;
    rd_en = 1'b1;
    wait (cs_n == 1'b0);
  endtask

  task automatic run(input logic [7:0] op, input logic [7:0] dum, input logic [15:0] col,
                     input logic [2:0] mode, input logic [4:0] ns, input logic [7:0] sp, input bit ien);
    setup(op, dum, col, mode, ns, sp, ien);
    wait (cs_n == 1'b1);
    @(negedge clk);
    chk(cap_cmd == op, "R1 opcode", cap_cmd, op);
    chk(!bad_cmd, "R1 lanes", bad_cmd, 0);
    chk(cap_addr == col, "R2 address", cap_addr, col);
    chk(!bad_addr, "R2 lanes", bad_addr, 0);
    chk(!bad_dum, "R3 dummy undriven", bad_dum, 0);
    chk(rises == 8 + n_as + n_dum + tot * 8 / cur_w, "R3 clock count", rises, 8 + n_as + n_dum + tot * 8 / cur_w);
    chk(!bad_data, "R4 data undriven", bad_data, 0);
    chk(nbytes == tot, "R5 byte count", nbytes, tot);
    chk(sect_cnt == ns, "R6 final", sect_cnt, ns);
    chk(irq_pend == ien, "R8 done", irq_pend, ien);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(cs_n == 1'b1, "R7 hold done", cs_n, 1);
    end
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear_irq();
    @(negedge clk) irq_rd = 1'b1;
    @(negedge clk) irq_rd = 1'b0;
    chk(irq_pend == 1'b0, "R9 read clear", irq_pend, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sck == 1'b0, "R12 pins", {cs_n, sck}, 2'b10);
    chk(io_oe == 4'b0000, "R12 oe", io_oe, 0);
    chk(rx_valid == 1'b0 && sect_cnt == 0 && irq_pend == 1'b0, "R12 status", {rx_valid, sect_cnt, irq_pend}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(cs_n == 1'b1 && sck == 1'b0, "R7 no enable", {cs_n, sck}, 2'b10);
    end

    run(8'h03, 8'd8, 16'hA53C, 3'b000, 5'd2, 8'd16, 1'b1);
    @(negedge clk);
    chk(irq_pend == 1'b1, "R9 held until read", irq_pend, 1);
    clear_irq();
    run(8'h3B, 8'd8, 16'h0810, 3'b001, 5'd1, 8'd26, 1'b0);
    run(8'hEB, 8'd4, 16'h1234, 3'b110, 5'd3, 8'd28, 1'b1);
    clear_irq();
    run(8'hBB, 8'd0, 16'hFFFF, 3'b101, 5'd1, 8'd0, 1'b1);
    clear_irq();

    // R10 abort mid-transfer
    setup(8'h6B, 8'd8, 16'h0042, 3'b010, 5'd1, 8'd16, 1'b1);
    repeat (200) @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
    chk(cs_n == 1'b1 && sck == 1'b0, "R10 abort", {cs_n, sck}, 2'b10);
    repeat (10) @(negedge clk);
    chk(irq_pend == 1'b0, "R10 no done", irq_pend, 0);
    chk(nbytes < tot, "R10 partial", nbytes, tot);
    run(8'h0B, 8'd8, 16'h0100, 3'b000, 5'd1, 8'd16, 1'b0);

    // R11 zero sectors
    chk_irq = 1'b0;
    run(8'h03, 8'd2, 16'h0007, 3'b000, 5'd0, 8'd16, 1'b1);
    chk(nbytes == 0 && sect_cnt == 0, "R11 empty", {nbytes[7:0], sect_cnt}, 0);
    clear_irq();
    exp_irq = 1'b0;
    chk_irq = 1'b1;

    repeat (5) @(negedge clk);
    summary();
  end
endmodule